// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block is the software-facing register file of an interrupt routing unit. A bus master sees only two 32-bit locations: an index select register at offset 0x00 and a data window at offset 0x10. The master stores an index in the select register. Later window reads and writes then act on the internal register that the index names. Writing the select register changes only the stored index and touches no target register.

Behind the window sit three read-only identity words and a redirection table. The identity words are a device identifier, a version/capacity word and an arbitration identifier. The table has one 64-bit entry per interrupt input, and each entry is reached as two 32-bit halves. Every table entry is exported as a flat vector to the pin logic that raises interrupts. The pin logic in turn supplies two live status bits per entry, and the window shows them in place of the stored bits.

The bus port is a single-cycle strobe interface with no wait states. Read data appears on the cycle after the read strobe.

Top module: `irw_window`

## Requirements
- R1: A write to offset 0x00 stores bits 7:0 of the write data as the index. A read of offset 0x00 returns that index in bits 7:0 with zeros above. A select write leaves every table entry unchanged.
- R2: Index 0 reads as DEV_ID in bits 27:24, with every other bit zero. Window writes to index 0 have no effect.
- R3: Index 1 reads as VERSION in bits 7:0 and NUM_ENTRIES-1 in bits 23:16, with all other bits zero. It is read-only.
- R4: Index 2 reads as ARB_ID in bits 27:24, with all other bits zero. It is read-only.
- R5: Entry n is reached at index 0x10+2n for entry bits 31:0 and at index 0x11+2n for entry bits 63:32. Writes there update `entries_o[64n +: 64]`, and a read returns the written value.
- R6: Entry bits 12 and 14 cannot be written. On a read of the lower half, bit 12 shows `stat_i[n]` and bit 14 shows `rirr_i[n]`. In `entries_o` these two bits are always 0.
- R7: Indexes 3 to 0x0F, and every index at or above 0x10+2*NUM_ENTRIES, read as zero. Window writes to them change no entry.
- R8: After reset the index is 0 and the read data is 0. Every entry holds only its mask bit (bit 16) set, so it equals 0x0000_0000_0001_0000.
- R9: The read data register loads only on a cycle with `bus_rd` high, and its value is visible on the next cycle. Without a read strobe it holds its value.
- R10: Accesses to any offset other than 0x00 and 0x10 have no effect, and reads of such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| stat_i | input | NUM_ENTRIES | Live delivery status bit per entry |
| rirr_i | input | NUM_ENTRIES | Live remote request bit per entry |
| entries_o | output | 64*NUM_ENTRIES | Stored redirection entries, entry n at bits 64n+63:64n |

## Verification
The embedded assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that the identity-read check fires only for a read strobe at the window offset with index 0, so no select write may share that cycle. The stimulus meets both conditions by construction: every access is a task that raises exactly one strobe for one cycle and then idles a cycle. The pin-status inputs change only between accesses, so a lower-half read sees them settled.

// File: rtl/irw_pkg.sv
// Package: shared offsets, field positions and write masks for the
// indirect register window. Assumes 8-bit byte offsets and 8-bit indexes.
package irw_pkg;
    localparam logic [7:0] SEL_OFS   = 8'h00;
    localparam logic [7:0] WIN_OFS   = 8'h10;
    localparam logic [7:0] IDX_ID    = 8'h00;
    localparam logic [7:0] IDX_VER   = 8'h01;
    localparam logic [7:0] IDX_ARB   = 8'h02;
    localparam int         TBL_BASE  = 16;
    localparam int         MASK_POS  = 16;
    localparam int         STAT_POS  = 12;
    localparam int         RIRR_POS  = 14;
    localparam int         MAX_ENT   = 24;

    // bits of the lower half that the bus may not write
    localparam logic [31:0] LO_WMASK = ~((32'd1 << STAT_POS) | (32'd1 << RIRR_POS));
    localparam logic [63:0] ENT_RST  = 64'd1 << MASK_POS;
endpackage

// File: rtl/irw_index.sv
// Index select register. Holds the index written at the select offset.
// Assumes the caller qualifies sel_wr with the address decode.
module irw_index (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [7:0] wdata,
    output logic [7:0] idx
);
    // store a new index on every select write
    always_ff @(posedge clk) begin
        if (!rst_n)      idx <= 8'h00;
        else if (sel_wr) idx <= wdata;
    end

    // R1
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(idx));
endmodule

// File: rtl/irw_table.sv
// Redirection table storage. One 64-bit register per entry, written a
// 32-bit half at a time through the window. Assumes win_wr is already
// qualified with the window offset. Bits 12 and 14 are never stored.
module irw_table #(
    parameter int NUM_ENTRIES = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        win_wr,
    input  logic [7:0]                  idx,
    input  logic [31:0]                 wdata,
    output logic [NUM_ENTRIES-1:0][63:0] ent
);
    import irw_pkg::*;

    localparam int TOP_IDX = TBL_BASE + 2 * NUM_ENTRIES;

    for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_ent
        localparam logic [7:0] LO_IDX = 8'(TBL_BASE + 2 * n);
        localparam logic [7:0] HI_IDX = 8'(TBL_BASE + 2 * n + 1);

        // update the addressed half of entry n
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[n] <= ENT_RST;
            end else if (win_wr && idx == LO_IDX) begin
                ent[n][31:0] <= wdata & LO_WMASK;
            end else if (win_wr && idx == HI_IDX) begin
                ent[n][63:32] <= wdata;
            end
        end
    end

    // R5
    tbl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_wr |=> $stable(ent));

    // R7
    tbl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && (32'(idx) >= TOP_IDX || 32'(idx) < TBL_BASE)) |=> $stable(ent));
endmodule

// File: rtl/irw_readmux.sv
// Read selection. Builds the 32-bit word for the current access from the
// index, the identity constants, the table and the live status inputs.
// Purely combinational; the top registers the result.
module irw_readmux #(
    parameter int         NUM_ENTRIES = 24,
    parameter logic [3:0] DEV_ID      = 4'h7,
    parameter logic [3:0] ARB_ID      = 4'hB,
    parameter logic [7:0] VERSION     = 8'h20
) (
    input  logic [7:0]                   bus_addr,
    input  logic [7:0]                   idx,
    input  logic [NUM_ENTRIES-1:0][63:0] ent,
    input  logic [NUM_ENTRIES-1:0]       stat_i,
    input  logic [NUM_ENTRIES-1:0]       rirr_i,
    output logic [31:0]                  word
);
    import irw_pkg::*;

    localparam logic [7:0] MAX_ENT_M1 = 8'(NUM_ENTRIES - 1);

    logic [31:0] win_word;

    // decode the indexed register behind the window
    always_comb begin
        win_word = 32'h0;
        case (idx)
            IDX_ID:  win_word = {4'h0, DEV_ID, 24'h0};
            IDX_VER: win_word = {8'h0, MAX_ENT_M1, 8'h0, VERSION};
            IDX_ARB: win_word = {4'h0, ARB_ID, 24'h0};
            default: win_word = 32'h0;
        endcase
        for (int k = 0; k < NUM_ENTRIES; k++) begin
            if (idx == 8'(TBL_BASE + 2 * k)) begin
                win_word           = ent[k][31:0];
                win_word[STAT_POS] = stat_i[k];
                win_word[RIRR_POS] = rirr_i[k];
            end else if (idx == 8'(TBL_BASE + 2 * k + 1)) begin
                win_word = ent[k][63:32];
            end
        end
    end

    // choose between the select register, the window and nothing
    always_comb begin
        if (bus_addr == SEL_OFS)      word = {24'h0, idx};
        else if (bus_addr == WIN_OFS) word = win_word;
        else                          word = 32'h0;
    end
endmodule

// File: rtl/irw_window.sv
// Top of the indirect register window. Decodes the two bus offsets,
// holds the index, the redirection table and the registered read data.
// Assumes one strobe per cycle; read data follows the strobe by one cycle.
module irw_window #(
    parameter int         NUM_ENTRIES = 24,
    parameter logic [3:0] DEV_ID      = 4'h7,
    parameter logic [3:0] ARB_ID      = 4'hB,
    parameter logic [7:0] VERSION     = 8'h20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [7:0]                bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_ENTRIES-1:0]    stat_i,
    input  logic [NUM_ENTRIES-1:0]    rirr_i,
    output logic [64*NUM_ENTRIES-1:0] entries_o
);
    import irw_pkg::*;

    logic                         sel_wr;
    logic                         win_wr;
    logic [7:0]                   idx;
    logic [NUM_ENTRIES-1:0][63:0] ent;
    logic [31:0]                  rd_word;

    assign sel_wr    = bus_wr && bus_addr == SEL_OFS;
    assign win_wr    = bus_wr && bus_addr == WIN_OFS;
    assign entries_o = ent;

    irw_index u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_wr (sel_wr),
        .wdata  (bus_wdata[7:0]),
        .idx    (idx)
    );

    irw_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .win_wr (win_wr),
        .idx    (idx),
        .wdata  (bus_wdata),
        .ent    (ent)
    );

    irw_readmux #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .DEV_ID      (DEV_ID),
        .ARB_ID      (ARB_ID),
        .VERSION     (VERSION)
    ) u_readmux (
        .bus_addr (bus_addr),
        .idx      (idx),
        .ent      (ent),
        .stat_i   (stat_i),
        .rirr_i   (rirr_i),
        .word     (rd_word)
    );

    // capture read data on the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= 32'h0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R2
    id_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == WIN_OFS && idx == IDX_ID)
        |=> bus_rdata == {4'h0, DEV_ID, 24'h0});

    // R10
    stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != SEL_OFS && bus_addr != WIN_OFS) |=> bus_rdata == 32'h0);
endmodule

// File: tb/irw_window_test.sv
// Scoreboard bench: read tasks push expected words, a monitor pops and
// compares them one cycle after each read strobe.
module irw_window_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       bus_addr = 8'h0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [31:0]      bus_wdata = 32'h0;
    logic [31:0]      bus_rdata;
    logic [N-1:0]     stat_i = '0;
    logic [N-1:0]     rirr_i = '0;
    logic [64*N-1:0]  entries_o;

    int total = 0;
    int bad = 0;
    logic rd_d = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irw_window #(.NUM_ENTRIES(N), .DEV_ID(4'h7), .ARB_ID(4'hB), .VERSION(8'h20)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stat_i(stat_i), .rirr_i(rirr_i),
        .entries_o(entries_o)
    );

    // note which edges captured a read
    always @(posedge clk) rd_d <= bus_rd && rst_n;

    // monitor: compare read data one cycle after the strobe
    always @(negedge clk) begin
        if (rd_d) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard: unexpected read, actual %h expected none", bus_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic check64(input logic [63:0] act, input logic [63:0] exp, input string t);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic win_read(input logic [7:0] i, input logic [31:0] e, input string t);
        bus_write(8'h00, {24'h0, i});
        bus_read(8'h10, e, t);
    endtask

    task automatic win_write(input logic [7:0] i, input logic [31:0] d);
        bus_write(8'h00, {24'h0, i});
        bus_write(8'h10, d);
    endtask

    function automatic logic [63:0] ent_of(input int n);
        return entries_o[64*n +: 64];
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stimulus
        logic [64*N-1:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        check64({32'h0, bus_rdata}, 64'h0, "R8 rdata after reset");
        check64(ent_of(0), 64'h0000_0000_0001_0000, "R8 entry 0 reset");
        check64(ent_of(N-1), 64'h0000_0000_0001_0000, "R8 last entry reset");
        bus_read(8'h00, 32'h0, "R8 index after reset");
        win_read(8'h1A, 32'h0001_0000, "R8 entry 5 low reset");
        win_read(8'h1B, 32'h0, "R8 entry 5 high reset");

        // R2 R3 R4 identity words
        win_read(8'h00, 32'h0700_0000, "R2 id word");
        win_read(8'h01, 32'h0017_0020, "R3 version word");
        win_read(8'h02, 32'h0B00_0000, "R4 arbitration word");
        snap = entries_o;
        win_write(8'h00, 32'hFFFF_FFFF);
        win_write(8'h01, 32'hFFFF_FFFF);
        win_write(8'h02, 32'h0000_0000);
        win_read(8'h00, 32'h0700_0000, "R2 id after write");
        win_read(8'h01, 32'h0017_0020, "R3 version after write");
        win_read(8'h02, 32'h0B00_0000, "R4 arb after write");
        check64({63'h0, entries_o == snap}, 64'h1, "R2 identity writes leave table");

        // R1 select write stores index only
        snap = entries_o;
        bus_write(8'h00, 32'hABCD_EF12);
        bus_read(8'h00, 32'h0000_0012, "R1 select readback");
        check64({63'h0, entries_o == snap}, 64'h1, "R1 select write leaves table");

        // R5 split halves, R6 read-only bits
        win_write(8'h12, 32'hFFFF_FFFF);
        win_write(8'h13, 32'hA500_0000);
        win_read(8'h12, 32'hFFFF_AFFF, "R6 low half drops bits 12 and 14");
        win_read(8'h13, 32'hA500_0000, "R5 entry 1 high half");
        check64(ent_of(1), 64'hA500_0000_FFFF_AFFF, "R5 entry 1 exported");
        check64(ent_of(0), 64'h0000_0000_0001_0000, "R5 neighbour entry 0 untouched");
        win_write(8'h3F, 32'h1234_5678);
        win_write(8'h3E, 32'h0000_20C1);
        win_read(8'h3F, 32'h1234_5678, "R5 last entry high half");
        check64(ent_of(N-1), 64'h1234_5678_0000_20C1, "R5 last entry exported");
        stat_i[1] = 1'b1; rirr_i[1] = 1'b1;
        win_read(8'h12, 32'hFFFF_FFFF, "R6 live bits on entry 1");
        stat_i[1] = 1'b0; rirr_i[1] = 1'b0; stat_i[N-1] = 1'b1;
        win_read(8'h3E, 32'h0000_30C1, "R6 status bit on last entry");
        stat_i = '0;
        check64(ent_of(1), 64'hA500_0000_FFFF_AFFF, "R6 exported bits stay zero");

        // R7 undefined and out-of-range indexes
        snap = entries_o;
        win_write(8'h40, 32'hFFFF_FFFF);
        win_write(8'h05, 32'hFFFF_FFFF);
        win_write(8'h0F, 32'hFFFF_FFFF);
        win_read(8'h40, 32'h0, "R7 beyond table reads zero");
        win_read(8'h03, 32'h0, "R7 index 3 reads zero");
        win_read(8'h0F, 32'h0, "R7 index 0x0F reads zero");
        check64({63'h0, entries_o == snap}, 64'h1, "R7 stray writes leave table");

        // R10 other offsets ignored
        bus_write(8'h00, 32'h0000_0014);
        bus_write(8'h04, 32'h0000_0016);
        bus_write(8'h14, 32'hDEAD_BEEF);
        bus_read(8'h00, 32'h0000_0014, "R10 stray write keeps index");
        bus_read(8'h08, 32'h0, "R10 stray offset reads zero");
        check64({63'h0, entries_o == snap}, 64'h1, "R10 stray writes leave table");

        // R9 read data holds without a strobe
        win_read(8'h13, 32'hA500_0000, "R9 read before idle");
        repeat (4) @(negedge clk);
        check64({32'h0, bus_rdata}, {32'h0, 32'hA500_0000}, "R9 rdata held");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule